// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block holds an eight-entry file of 96-bit floating-point registers and moves a chosen subset of them to or from memory. Each register travels as three 32-bit beats on a valid/ready request channel, and the address advances as the beats go. A single start pulse supplies the transfer parameters. These are the direction, an addressing-mode code, a base address, and an 8-bit register mask. The mask comes either from a static instruction field or from the low byte of a general-register value.

The sequencer checks the addressing mode against the direction before it issues anything. In predecrement mode it visits the registers from the highest index down and lets the address fall. In every other mode it visits them from the lowest index up and lets the address rise. Registers that are not selected cost no cycles and make no access. A fault returned on any beat ends the sequence at once. The block does no rounding or conversion and keeps no status bits.

Back-pressure rules: a beat is offered by raising `beat_valid`. Address, write flag and write data then stay fixed until `beat_ready` is seen high at a clock edge. That edge is the handshake. On a load beat, `beat_rdata` and `beat_fault` are sampled at the handshake edge. On a store beat, only `beat_fault` is sampled. The memory side may hold `beat_ready` low for any number of cycles.

Top module: `fpr_xfer_seq`

## Requirements
- R1: With `to_mem`=1 every beat has `beat_write`=1 and carries register words. With `to_mem`=0 every beat has `beat_write`=0, and the word on `beat_rdata` at the handshake is written into the register file.
- R2: With `list_dyn`=1 the mask is bits 7:0 of `list_gpr`, and bits 31:8 have no effect. With `list_dyn`=0 the mask is `list_static`.
- R3: Predecrement mode is `ea_code[5:3]`=4. In that mode registers are visited 7 down to 0 and mask bit r selects register r. In every other mode registers are visited 0 up to 7 and mask bit 7-r selects register r.
- R4: Each selected register takes exactly three beats. Word 0 is bits 95:64, word 1 is bits 63:32 and word 2 is bits 31:0. In predecrement mode the words go in the order 2,1,0; otherwise they go 0,1,2.
- R5: In predecrement mode the k-th beat (k from 1) uses address base-4k. In any other mode it uses base+4(k-1).
- R6: A store is illegal when `ea_code` < 16, when `ea_code[5:3]`=3, or when `ea_code` >= 58. An illegal store raises `illegal` and `done` together in the cycle after start, issues no beats and changes no register.
- R7: A load is illegal when `ea_code` < 16, when `ea_code[5:3]`=4, or when `ea_code` >= 60. It behaves as in R6.
- R8: Unselected registers produce no beats. A transfer issues 3 x (set bits in the mask) beats, with no idle cycle between registers while `beat_ready` stays high.
- R9: A handshake with `beat_fault`=1 is the last beat. `done` pulses in the next cycle and no further beat is offered. A faulting load beat is not written.
- R10: A legal start with an empty mask raises `done` in the next cycle and issues no beats.
- R11: While `beat_valid`=1 and `beat_ready`=0, `beat_valid`, `beat_addr`, `beat_write` and `beat_wdata` hold their values into the next cycle.
- R12: `start` and all parameter inputs are ignored while a transfer is in progress.
- R13: `done` is a one-cycle pulse in the cycle after the last handshake. After reset `done`, `illegal` and `beat_valid` are 0 and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| to_mem | input | 1 | 1: register file to memory, 0: memory to register file |
| list_dyn | input | 1 | 1: mask from `list_gpr`, 0: from `list_static` |
| list_static | input | 8 | Static register mask |
| list_gpr | input | 32 | General-register value; low byte is the dynamic mask |
| ea_code | input | 6 | Addressing-mode code, group in bits 5:3 |
| base_addr | input | 32 | Effective base address |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Memory accepts the beat |
| beat_write | output | 1 | Beat is a store |
| beat_addr | output | 32 | Beat address |
| beat_wdata | output | 32 | Store data |
| beat_rdata | input | 32 | Load data, sampled at handshake |
| beat_fault | input | 1 | Access failed, sampled at handshake |
| illegal | output | 1 | Addressing mode rejected (pulse) |
| done | output | 1 | Transfer finished (pulse) |

## Verification
The assertions assume that `start` falls by the cycle in which `done` appears. Without that, a held start with an illegal code would restart every cycle and break the one-cycle `done` rule. They also assume that `beat_fault` carries meaning only at a handshake. The bench therefore raises start for a single cycle. Even in the run that holds start high across a busy transfer, the bench drops start on the cycle `done` is seen. It drives `beat_fault` only in cycles where it also grants `beat_ready`. The random `beat_ready` and random mode codes otherwise range freely over all 64 codes and both directions.

// File: rtl/fxs_pkg.sv
package fxs_pkg;

  localparam int unsigned EA_W = 6;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // addressing-mode groups that the legality check decodes (ea_code[5:3])
  localparam logic [2:0] EA_GRP_AREG    = 3'd1;
  localparam logic [2:0] EA_GRP_POSTINC = 3'd3;
  localparam logic [2:0] EA_GRP_PREDEC  = 3'd4;
  localparam logic [2:0] EA_GRP_EXT     = 3'd7;
  // register-field limits inside the extended group
  localparam logic [2:0] EXT_STORE_LIM  = 3'd2;  // pc-relative and above
  localparam logic [2:0] EXT_LOAD_LIM   = 3'd4;  // immediate and above

endpackage

// File: rtl/fxs_mode_check.sv
module fxs_mode_check
  import fxs_pkg::*;
(
  input  logic [EA_W-1:0] code,
  input  logic            to_mem,
  output logic            bad_mode,
  output logic            is_predec
);

  logic [2:0] grp;
  logic [2:0] sub;
  logic       reg_direct;
  logic       store_bad;
  logic       load_bad;

  assign grp        = code[5:3];
  assign sub        = code[2:0];
  assign reg_direct = (grp <= EA_GRP_AREG);
  assign is_predec  = (grp == EA_GRP_PREDEC);

  always_comb begin
    store_bad = (grp == EA_GRP_POSTINC) ||
                ((grp == EA_GRP_EXT) && (sub >= EXT_STORE_LIM));
    load_bad  = (grp == EA_GRP_PREDEC) ||
                ((grp == EA_GRP_EXT) && (sub >= EXT_LOAD_LIM));
    bad_mode  = reg_direct || (to_mem ? store_bad : load_bad);
  end

endmodule

// File: rtl/fxs_pick.sv
module fxs_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  assign found = |req;

  // lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/fxs_regfile.sv
module fxs_regfile #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned WORDS  = 3,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_reg,
  input  logic [CNT_W-1:0]  wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_reg,
  input  logic [CNT_W-1:0]  rd_word,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] rd_bank [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [WORD_W-1:0] words_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) words_q[w] <= '0;
      end else if (we && (wr_reg == IDX_W'(r))) begin
        words_q[wr_word] <= wr_data;
      end
    end

    assign rd_bank[r] = words_q[rd_word];
  end

  assign rd_data = rd_bank[rd_reg];

endmodule

// File: rtl/fpr_xfer_seq.sv
module fpr_xfer_seq
  import fxs_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter int unsigned WORDS  = 3,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned GPR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_mem,
  input  logic              list_dyn,
  input  logic [NREG-1:0]   list_static,
  input  logic [GPR_W-1:0]  list_gpr,
  input  logic [EA_W-1:0]   ea_code,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic              beat_write,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [WORD_W-1:0] beat_wdata,
  input  logic [WORD_W-1:0] beat_rdata,
  input  logic              beat_fault,
  output logic              illegal,
  output logic              done
);

  localparam int unsigned IDX_W = $clog2(NREG);
  localparam int unsigned CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(WORDS - 1);
  localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(NREG - 1);

  // ---------------- list selection and visit-order mask ----------------
  logic [NREG-1:0] list_sel;
  logic [NREG-1:0] vis_mask;
  logic            gpr_hi_unused;

  assign list_sel      = list_dyn ? list_gpr[NREG-1:0] : list_static;
  assign gpr_hi_unused = ^list_gpr[GPR_W-1:NREG];

  // visit slot i always consumes mask bit NREG-1-i
  for (genvar i = 0; i < NREG; i++) begin : g_vis
    assign vis_mask[i] = list_sel[NREG-1-i];
  end

  // ---------------- mode legality ----------------
  logic mode_bad;
  logic mode_predec;

  fxs_mode_check u_mode (
    .code      (ea_code),
    .to_mem    (to_mem),
    .bad_mode  (mode_bad),
    .is_predec (mode_predec)
  );

  // ---------------- sequencing state ----------------
  seq_state_e        state_q;
  logic [NREG-1:0]   pend_q;
  logic              predec_q;
  logic              store_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              illegal_q;

  logic              pend_found;
  logic [IDX_W-1:0]  vis_idx;

  fxs_pick #(.N(NREG), .IDX_W(IDX_W)) u_pick (
    .req   (pend_q),
    .found (pend_found),
    .idx   (vis_idx)
  );

  logic [IDX_W-1:0]  cur_reg;
  logic [CNT_W-1:0]  cur_word;
  logic              hs;
  logic              last_word;
  logic [NREG-1:0]   pend_after;
  logic              finish;
  logic              accept_start;
  logic [WORD_W-1:0] rf_rdata;

  assign cur_reg    = predec_q ? (TOP_IDX - vis_idx) : vis_idx;
  assign cur_word   = predec_q ? (LAST_CNT - cnt_q) : cnt_q;
  assign beat_valid = (state_q == SEQ_RUN) && pend_found;
  assign hs         = beat_valid && beat_ready;
  assign last_word  = (cnt_q == LAST_CNT);

  always_comb begin
    pend_after = pend_q;
    if (last_word) pend_after[vis_idx] = 1'b0;
  end

  assign finish       = hs && (beat_fault || (last_word && (pend_after == '0)));
  assign accept_start = (state_q == SEQ_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      pend_q    <= '0;
      predec_q  <= 1'b0;
      store_q   <= 1'b0;
      addr_q    <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      if (accept_start) begin
        if (mode_bad) begin
          illegal_q <= 1'b1;
          done_q    <= 1'b1;
        end else if (vis_mask == '0) begin
          done_q <= 1'b1;
        end else begin
          state_q  <= SEQ_RUN;
          pend_q   <= vis_mask;
          predec_q <= mode_predec;
          store_q  <= to_mem;
          addr_q   <= mode_predec ? (base_addr - STEP) : base_addr;
          cnt_q    <= '0;
        end
      end else if (hs) begin
        if (finish) begin
          state_q <= SEQ_IDLE;
          pend_q  <= '0;
          cnt_q   <= '0;
          done_q  <= 1'b1;
        end else begin
          addr_q <= predec_q ? (addr_q - STEP) : (addr_q + STEP);
          pend_q <= pend_after;
          cnt_q  <= last_word ? '0 : (cnt_q + CNT_W'(1));
        end
      end
    end
  end

  // ---------------- register file ----------------
  fxs_regfile #(
    .NREG(NREG), .WORDS(WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (hs && !store_q && !beat_fault),
    .wr_reg  (cur_reg),
    .wr_word (cur_word),
    .wr_data (beat_rdata),
    .rd_reg  (cur_reg),
    .rd_word (cur_word),
    .rd_data (rf_rdata)
  );

  assign beat_write = store_q;
  assign beat_addr  = addr_q;
  assign beat_wdata = store_q ? rf_rdata : '0;
  assign illegal    = illegal_q;
  assign done       = done_q;

  // ---------------- assertions ----------------
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) &&
                                     $stable(beat_write) && $stable(beat_wdata))); // R11

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !beat_fault && !finish) |=>
      (beat_addr == ($past(predec_q) ? ($past(beat_addr) - STEP)
                                     : ($past(beat_addr) + STEP)))); // R5

  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_fault) |=> (!beat_valid && done)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R13

  AST_STORE_POSTINC_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_start && to_mem && (ea_code[5:3] == EA_GRP_POSTINC)) |=> (illegal && done)); // R6

  AST_LOAD_PREDEC_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_start && !to_mem && (ea_code[5:3] == EA_GRP_PREDEC)) |=> (illegal && done)); // R7

  AST_ILLEGAL_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !beat_valid); // R6

endmodule

// File: tb/tb_fpr_xfer_seq.sv
module tb_fpr_xfer_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        to_mem = 1'b0;
  logic        list_dyn = 1'b0;
  logic [7:0]  list_static = '0;
  logic [31:0] list_gpr = '0;
  logic [5:0]  ea_code = '0;
  logic [31:0] base_addr = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic        beat_write;
  logic [31:0] beat_addr;
  logic [31:0] beat_wdata;
  logic [31:0] beat_rdata = '0;
  logic        beat_fault = 1'b0;
  logic        illegal;
  logic        done;

  fpr_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem), .list_dyn(list_dyn),
    .list_static(list_static), .list_gpr(list_gpr), .ea_code(ea_code),
    .base_addr(base_addr), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_write(beat_write), .beat_addr(beat_addr), .beat_wdata(beat_wdata),
    .beat_rdata(beat_rdata), .beat_fault(beat_fault), .illegal(illegal), .done(done)
  );

  always #4 clk = ~clk;  // 125 MHz

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] salt = 32'h0;
  logic [31:0] shadow [8][3];

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 150000);
    bad = bad + 1;
    $display("FAIL watchdog: run hung, cycles=%0d expected below 150000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total = total + 1;
    if (got !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ (32'h5A5A1234 + salt);
  endfunction

  function automatic bit bad_mode(input bit st, input logic [5:0] c);
    if (c < 6'd16) return 1'b1;
    if (st) return (c[5:3] == 3'd3) || (c >= 6'd58);
    return (c[5:3] == 3'd4) || (c >= 6'd60);
  endfunction

  task automatic run_op(input bit st, input bit dyn, input logic [7:0] stat,
                        input logic [31:0] gpr, input logic [5:0] code,
                        input logic [31:0] base, input int fault_at,
                        input bit hold_start, input string req);
    logic [31:0] e_addr [24];
    int          e_reg  [24];
    int          e_word [24];
    int          n = 0;
    int          n_exp;
    int          idx = 0;
    int          cyc = 0;
    int          last_hs = -1;
    bit          got_done = 0;
    bit          ill;
    bit          pre;
    bit          prev_stall = 0;
    logic [31:0] prev_addr = '0;
    logic [7:0]  lst;
    lst = dyn ? gpr[7:0] : stat;
    ill = bad_mode(st, code);
    pre = (code[5:3] == 3'd4);
    if (!ill) begin
      for (int k = 0; k < 8; k++) begin
        int r = pre ? 7 - k : k;
        bit sel = pre ? lst[r] : lst[7 - r];
        if (sel) begin
          for (int j = 0; j < 3; j++) begin
            e_reg[n]  = r;
            e_word[n] = pre ? 2 - j : j;
            e_addr[n] = pre ? base - 32'(4 * (n + 1)) : base + 32'(4 * n);
            n = n + 1;
          end
        end
      end
    end
    n_exp = (fault_at >= 0 && fault_at < n) ? fault_at + 1 : n;
    salt = salt + 32'h1111;
    @(negedge clk);
    start = 1'b1; to_mem = st; list_dyn = dyn; list_static = stat;
    list_gpr = gpr; ea_code = code; base_addr = base;
    @(posedge clk);
    while (!got_done && cyc < 400) begin
      @(negedge clk);
      cyc = cyc + 1;
      if (hold_start) begin
        // R12: scramble parameters while busy
        to_mem = ~st; list_static = ~stat; list_gpr = ~gpr; base_addr = base ^ 32'hFF0;
      end else begin
        start = 1'b0;
      end
      if (prev_stall) check({req, "/R11 hold"}, beat_addr, prev_addr);
      if (done) begin
        got_done = 1;
        start = 1'b0; beat_ready = 1'b0; beat_fault = 1'b0;
      end else if (beat_valid) begin
        bit rdy = ($urandom_range(0, 3) != 0);
        beat_ready = rdy;
        beat_fault = 1'b0;
        beat_rdata = mem_fn(beat_addr);
        prev_stall = !rdy;
        prev_addr = beat_addr;
        if (rdy) begin
          if (idx >= n) begin
            check({req, "/R8 extra beat"}, 32'(idx), 32'(n));
          end else begin
            bit flt = (idx == fault_at);
            beat_fault = flt;
            check({req, "/R1 dir"}, {31'b0, beat_write}, {31'b0, st});
            check({req, "/R5 addr"}, beat_addr, e_addr[idx]);
            if (st) check({req, "/R4 data"}, beat_wdata, shadow[e_reg[idx]][e_word[idx]]);
            else if (!flt) shadow[e_reg[idx]][e_word[idx]] = mem_fn(beat_addr);
          end
          idx = idx + 1;
          last_hs = cyc;
        end
      end else begin
        beat_ready = 1'b0;
        prev_stall = 0;
      end
    end
    check({req, " done seen R13"}, {31'b0, got_done}, 32'd1);
    check({req, " illegal flag R6/R7"}, {31'b0, illegal}, {31'b0, ill});
    check({req, " beat count R8/R9"}, 32'(idx), 32'(n_exp));
    check({req, " no beat at done R9"}, {31'b0, beat_valid}, 32'd0);
    if (idx > 0) check({req, " done timing R13"}, 32'(cyc - last_hs), 32'd1);
    else check({req, " immediate done R10"}, 32'(cyc), 32'd1);
    @(negedge clk);
    check({req, " done pulse R13"}, {31'b0, done}, 32'd0);
  endtask

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h1F2E3D4C);
    for (int r = 0; r < 8; r++) for (int w = 0; w < 3; w++) shadow[r][w] = '0;
    repeat (3) @(negedge clk);
    check("R13 reset done", {31'b0, done}, 32'd0);
    check("R13 reset illegal", {31'b0, illegal}, 32'd0);
    check("R13 reset valid", {31'b0, beat_valid}, 32'd0);
    rst_n = 1'b1;
    // reset contents read back as zero, ascending order
    run_op(1, 0, 8'hFF, 0, 6'd16, 32'h1000, -1, 0, "R13 R4 store zero");
    run_op(0, 0, 8'hFF, 0, 6'd24, 32'h2000, -1, 0, "R1 load all postinc");
    run_op(1, 0, 8'hFF, 0, 6'd40, 32'h3000, -1, 0, "R4 store all disp");
    run_op(1, 0, 8'h81, 0, 6'd33, 32'h4000, -1, 0, "R3 predec store 81");
    run_op(1, 0, 8'h06, 0, 6'd34, 32'h4400, -1, 0, "R3 predec store 06");
    run_op(1, 0, 8'h06, 0, 6'd16, 32'h4800, -1, 0, "R3 ascend store 06");
    run_op(0, 0, 8'h30, 0, 6'd57, 32'h5000, -1, 0, "R1 load abs");
    run_op(1, 0, 8'hFF, 0, 6'd18, 32'h5400, -1, 0, "R1 store check");
    run_op(1, 1, 8'hFF, 32'hABCD_0005, 6'd16, 32'h6000, -1, 0, "R2 dynamic list");
    run_op(1, 0, 8'h24, 32'h0000_00FF, 6'd40, 32'h6400, -1, 0, "R2 static list");
    run_op(1, 0, 8'h24, 0, 6'd48, 32'h6800, -1, 0, "R8 skip store");
    run_op(1, 0, 8'hFF, 0, 6'd24, 32'h7000, -1, 0, "R6 store postinc");
    run_op(1, 0, 8'hFF, 0, 6'd5,  32'h7000, -1, 0, "R6 store dreg");
    run_op(1, 0, 8'hFF, 0, 6'd58, 32'h7000, -1, 0, "R6 store pcrel");
    run_op(1, 0, 8'hFF, 0, 6'd57, 32'h7000, -1, 0, "R6 store abs legal");
    run_op(0, 0, 8'hFF, 0, 6'd32, 32'h7000, -1, 0, "R7 load predec");
    run_op(0, 0, 8'hFF, 0, 6'd12, 32'h7000, -1, 0, "R7 load areg");
    run_op(0, 0, 8'hFF, 0, 6'd60, 32'h7000, -1, 0, "R7 load imm");
    run_op(0, 0, 8'h01, 0, 6'd59, 32'h7100, -1, 0, "R7 load pc index legal");
    run_op(1, 0, 8'h00, 0, 6'd16, 32'h7000, -1, 0, "R10 empty static");
    run_op(1, 1, 8'hFF, 32'hFFFF_FF00, 6'd16, 32'h7000, -1, 0, "R10 R2 empty dyn");
    run_op(0, 0, 8'hFF, 0, 6'd16, 32'h8000, 4, 0, "R9 load fault");
    run_op(1, 0, 8'hFF, 0, 6'd16, 32'h8400, -1, 0, "R9 after fault");
    run_op(1, 0, 8'hC0, 0, 6'd35, 32'h8800, 0, 0, "R9 store fault first");
    run_op(1, 0, 8'h42, 0, 6'd16, 32'h9000, -1, 1, "R12 start held");
    for (int t = 0; t < 60; t++) begin
      bit st = 1'($urandom_range(0, 1));
      bit dy = 1'($urandom_range(0, 1));
      logic [7:0] sl = 8'($urandom);
      logic [31:0] gp = $urandom;
      logic [5:0] cd = 6'($urandom_range(0, 63));
      logic [31:0] bs = {16'h0, 4'h8 + 4'($urandom_range(0, 3)), 10'($urandom), 2'b00};
      int fa = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 12)) : -1;
      run_op(st, dy, sl, gp, cd, bs, fa, 0, "R8 random");
    end
    run_op(1, 0, 8'hFF, 0, 6'd16, 32'hA000, -1, 0, "R4 final store");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule